// File: doc/BRIEF.md
# I/O Window Decoder with Bus-Width Control

This block compares each host I/O address against a small set of programmable windows. Every window holds a base word and a control word. The base word gives both where the window sits and how long it is. The control word gives the enable, the target socket, a wait-state count, address aliasing, a one-byte size and a bus-width policy. When a host I/O access falls inside an enabled window, the block registers a hit one cycle later. With the hit it presents the window number, the socket select, the wait count, the 16-bit-cycle indication and the address to pass on to the card.

Software programs the windows through an indirect register port. A window that serves an access records this in an accessed flag inside its control word, and software can read that flag back. The bus-width policy picks the 16-bit indication from one of four sources. It can follow the card's own 16-bit request pin. It can hold the indication off. It can hold it on. Or it can assert it only at offsets that are multiples of eight, which suits ATA/IDE task-file layouts where only the data register is word wide.

Top module: `iowin_decoder`

## Requirements
- R1: While reset is held and on the first cycle after it, all outputs are zero. Every base and control word reads back as 0x0000.
- R2: Window w has its base word at indirect index IDX_BASE+4w and its control word at IDX_BASE+4w+2. Writes to any index outside IDX_BASE to IDX_BASE+4*NWIN-1 change nothing. A read of such an index returns 0. In-range reads return the stored word combinationally.
- R3: A write to a base word clears bit 15 (enable) of the same window's control word. A window with bit 15 clear never hits.
- R4: Let k be the lowest set bit of the base word. The window spans 2^(k+1) bytes, aligned, and contains the base. A base word of zero spans the whole 64 KB space.
- R5: Control bit 9 makes the window exactly one byte long, at the address equal to the base word.
- R6: Control bit 7 makes the compare ignore host address bits 15:10.
- R7: The card address equals the host address, except when control bit 7 is set and bit 5 is clear. In that case only bits 9:0 pass and the upper bits are zero.
- R8: When control bits 11:10 are 00, the 16-bit indication follows the card 16-bit request input sampled with the address.
- R9: When bits 11:10 are 10 the 16-bit indication is 0. When they are 01 it is 1.
- R10: When bits 11:10 are 11, the 16-bit indication is 1 only when the offset of the address within the window is a multiple of 8.
- R11: When several windows match, the lowest-numbered window wins.
- R12: Outputs are registered. An access presented at one clock edge shows its result after that edge. Socket is control bits 14:12 and wait count is bits 4:0. With no hit or no access, all outputs are zero.
- R13: A hit sets control bit 8 (accessed) of the winning window. A software write loads bit 8 from the data. If a write and a hit reach the same window in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Indirect register write strobe |
| cfg_addr | input | 12 | Indirect register index |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data for cfg_addr (combinational) |
| io_valid | input | 1 | Host I/O access present this cycle |
| io_addr | input | 16 | Host I/O address |
| card_iois16 | input | 1 | Card requests a 16-bit cycle |
| win_hit | output | 1 | Registered hit |
| win_sel | output | 2 | Index of the winning window |
| sock_sel | output | 3 | Socket select of the winning window |
| wait_cnt | output | 5 | Wait count of the winning window |
| cyc16 | output | 1 | 16-bit cycle indication |
| card_addr | output | 16 | Address passed on to the card |

## Verification
The bench builds the decoder with its defaults: four windows placed at indirect index 0x200. With four windows, each one can carry a different feature at the same time: a dynamic-width window, an ATA-mode window, a forced 16-bit single-byte window and a forced 8-bit aliased window. Two of these windows are then made to overlap, which exercises the lowest-index priority. Because the index base is fixed, the indices just below and just above the window block serve as the out-of-range cases.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

    localparam int unsigned REG_W  = 16;
    localparam int unsigned SOCK_W = 3;
    localparam int unsigned WAIT_W = 5;

    // Address bits kept when a window aliases every 1 KB
    localparam logic [REG_W-1:0] ALIAS_KEEP = 16'h03FF;
    localparam logic [REG_W-1:0] ATA_STEP   = 16'h0007;

    typedef enum logic [1:0] {
        WID_CARD    = 2'b00,
        WID_FORCE16 = 2'b01,
        WID_FORCE8  = 2'b10,
        WID_ATA     = 2'b11
    } width_e;

    typedef struct packed {
        logic              enable;    // 15
        logic [SOCK_W-1:0] sock;      // 14:12
        width_e            width;     // 11:10
        logic              one_byte;  // 9
        logic              acc;       // 8
        logic              alias1k;   // 7
        logic              spare;     // 6
        logic              pass16;    // 5
        logic [WAIT_W-1:0] waits;     // 4:0
    } ctl_t;

    typedef struct packed {
        logic              hit;
        logic              cyc16;
        logic [SOCK_W-1:0] sock;
        logic [WAIT_W-1:0] waits;
        logic [REG_W-1:0]  card_addr;
    } look_t;

    // Mask of the address bits that lie inside the window.
    function automatic logic [REG_W-1:0] span_mask(input logic [REG_W-1:0] base,
                                                   input logic one_byte);
        logic [REG_W-1:0] low;
        low = base & (~base + 16'd1);
        if (one_byte) return '0;
        return (low << 1) - 16'd1;
    endfunction

endpackage

// File: rtl/iowin_regs.sv
module iowin_regs
    import iowin_pkg::*;
#(
    parameter int unsigned NWIN     = 4,
    parameter logic [11:0] IDX_BASE = 12'h200
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [11:0]            cfg_addr,
    input  logic [REG_W-1:0]       cfg_wdata,
    output logic [REG_W-1:0]       cfg_rdata,
    input  logic [NWIN-1:0]        acc_set,
    output logic [REG_W-1:0]       base_o    [NWIN],
    output logic [NWIN-1:0]        en_o,
    output logic [SOCK_W-1:0]      sock_o    [NWIN],
    output width_e                 width_o   [NWIN],
    output logic [NWIN-1:0]        one_byte_o,
    output logic [NWIN-1:0]        alias_o,
    output logic [NWIN-1:0]        pass16_o,
    output logic [WAIT_W-1:0]      waits_o   [NWIN]
);

    localparam int unsigned WIN_W = $clog2(NWIN);
    localparam logic [11:0] SPAN  = 12'(4 * NWIN);

    logic [11:0]      rel;
    logic             in_range;
    logic [WIN_W-1:0] wsel;
    logic             is_ctl;
    logic [REG_W-1:0] base_arr [NWIN];
    ctl_t             ctl_arr  [NWIN];

    assign rel      = cfg_addr - IDX_BASE;
    assign in_range = (cfg_addr >= IDX_BASE) && (rel < SPAN);
    assign wsel     = rel[WIN_W+1:2];
    assign is_ctl   = rel[1];

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        logic [REG_W-1:0] base_q;
        ctl_t             ctl_q;
        logic             hit_me;

        assign hit_me = cfg_we && in_range && (wsel == WIN_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                base_q <= '0;
                ctl_q  <= '0;
            end else begin
                if (hit_me) begin
                    if (is_ctl) begin
                        ctl_q <= ctl_t'(cfg_wdata);
                    end else begin
                        base_q       <= cfg_wdata;
                        ctl_q.enable <= 1'b0;
                    end
                end
                if (acc_set[w]) begin
                    ctl_q.acc <= 1'b1;
                end
            end
        end

        assign base_arr[w]   = base_q;
        assign ctl_arr[w]    = ctl_q;
        assign base_o[w]     = base_q;
        assign en_o[w]       = ctl_q.enable;
        assign sock_o[w]     = ctl_q.sock;
        assign width_o[w]    = ctl_q.width;
        assign one_byte_o[w] = ctl_q.one_byte;
        assign alias_o[w]    = ctl_q.alias1k;
        assign pass16_o[w]   = ctl_q.pass16;
        assign waits_o[w]    = ctl_q.waits;
    end

    always_comb begin
        cfg_rdata = '0;
        if (in_range) begin
            cfg_rdata = is_ctl ? REG_W'(ctl_arr[wsel]) : base_arr[wsel];
        end
    end

endmodule

// File: rtl/iowin_match.sv
module iowin_match
    import iowin_pkg::*;
(
    input  logic [REG_W-1:0]  base,
    input  logic              enable,
    input  logic [SOCK_W-1:0] sock,
    input  width_e            width,
    input  logic              one_byte,
    input  logic              alias1k,
    input  logic              pass16,
    input  logic [WAIT_W-1:0] waits,
    input  logic [REG_W-1:0]  addr,
    input  logic              iois16,
    output look_t             res
);

    logic [REG_W-1:0] span;
    logic [REG_W-1:0] cmp;
    logic             in_win;
    logic             ata16;

    always_comb begin
        span   = span_mask(base, one_byte);
        cmp    = ~span & (alias1k ? ALIAS_KEEP : '1);
        in_win = enable && (((addr ^ base) & cmp) == '0);
        ata16  = ((addr & span & ATA_STEP) == '0);
        res    = '0;
        if (in_win) begin
            res.hit       = 1'b1;
            res.sock      = sock;
            res.waits     = waits;
            res.card_addr = (alias1k && !pass16) ? (addr & ALIAS_KEEP) : addr;
            case (width)
                WID_CARD:    res.cyc16 = iois16;
                WID_FORCE16: res.cyc16 = 1'b1;
                WID_FORCE8:  res.cyc16 = 1'b0;
                default:     res.cyc16 = ata16;
            endcase
        end
    end

endmodule

// File: rtl/iowin_arbiter.sv
module iowin_arbiter
    import iowin_pkg::*;
#(
    parameter int unsigned NWIN = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     io_valid,
    input  look_t                    res [NWIN],
    output logic [NWIN-1:0]          acc_set,
    output logic                     win_hit,
    output logic [$clog2(NWIN)-1:0]  win_sel,
    output logic [SOCK_W-1:0]        sock_sel,
    output logic [WAIT_W-1:0]        wait_cnt,
    output logic                     cyc16,
    output logic [REG_W-1:0]         card_addr
);

    localparam int unsigned WIN_W = $clog2(NWIN);

    look_t            pick;
    logic             found;
    logic [WIN_W-1:0] win_n;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        win_n = '0;
        for (int w = 0; w < NWIN; w++) begin
            if (!found && res[w].hit) begin
                found = 1'b1;
                pick  = res[w];
                win_n = WIN_W'(w);
            end
        end
        acc_set = '0;
        if (io_valid && found) begin
            acc_set[win_n] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !(io_valid && found)) begin
            win_hit   <= 1'b0;
            win_sel   <= '0;
            sock_sel  <= '0;
            wait_cnt  <= '0;
            cyc16     <= 1'b0;
            card_addr <= '0;
        end else begin
            win_hit   <= 1'b1;
            win_sel   <= win_n;
            sock_sel  <= pick.sock;
            wait_cnt  <= pick.waits;
            cyc16     <= pick.cyc16;
            card_addr <= pick.card_addr;
        end
    end

endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder
    import iowin_pkg::*;
#(
    parameter int unsigned NWIN     = 4,
    parameter logic [11:0] IDX_BASE = 12'h200
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [11:0]             cfg_addr,
    input  logic [15:0]             cfg_wdata,
    output logic [15:0]             cfg_rdata,
    input  logic                    io_valid,
    input  logic [15:0]             io_addr,
    input  logic                    card_iois16,
    output logic                    win_hit,
    output logic [$clog2(NWIN)-1:0] win_sel,
    output logic [2:0]              sock_sel,
    output logic [4:0]              wait_cnt,
    output logic                    cyc16,
    output logic [15:0]             card_addr
);

    logic [REG_W-1:0]  base_w    [NWIN];
    logic [NWIN-1:0]   en_w;
    logic [SOCK_W-1:0] sock_w    [NWIN];
    width_e            width_w   [NWIN];
    logic [NWIN-1:0]   one_byte_w;
    logic [NWIN-1:0]   alias_w;
    logic [NWIN-1:0]   pass16_w;
    logic [WAIT_W-1:0] waits_w   [NWIN];
    logic [NWIN-1:0]   acc_set;
    look_t             res_w     [NWIN];

    iowin_regs #(.NWIN(NWIN), .IDX_BASE(IDX_BASE)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .acc_set    (acc_set),
        .base_o     (base_w),
        .en_o       (en_w),
        .sock_o     (sock_w),
        .width_o    (width_w),
        .one_byte_o (one_byte_w),
        .alias_o    (alias_w),
        .pass16_o   (pass16_w),
        .waits_o    (waits_w)
    );

    for (genvar w = 0; w < NWIN; w++) begin : g_match
        iowin_match u_match (
            .base     (base_w[w]),
            .enable   (en_w[w]),
            .sock     (sock_w[w]),
            .width    (width_w[w]),
            .one_byte (one_byte_w[w]),
            .alias1k  (alias_w[w]),
            .pass16   (pass16_w[w]),
            .waits    (waits_w[w]),
            .addr     (io_addr),
            .iois16   (card_iois16),
            .res      (res_w[w])
        );
    end

    iowin_arbiter #(.NWIN(NWIN)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .io_valid  (io_valid),
        .res       (res_w),
        .acc_set   (acc_set),
        .win_hit   (win_hit),
        .win_sel   (win_sel),
        .sock_sel  (sock_sel),
        .wait_cnt  (wait_cnt),
        .cyc16     (cyc16),
        .card_addr (card_addr)
    );

endmodule

// File: rtl/iowin_decoder_chk.sv
module iowin_decoder_chk #(
    parameter int unsigned NWIN     = 4,
    parameter logic [11:0] IDX_BASE = 12'h200
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    cfg_we,
    input logic [11:0]             cfg_addr,
    input logic [15:0]             cfg_rdata,
    input logic                    io_valid,
    input logic                    win_hit,
    input logic [$clog2(NWIN)-1:0] win_sel,
    input logic [2:0]              sock_sel,
    input logic [4:0]              wait_cnt,
    input logic                    cyc16,
    input logic [15:0]             card_addr
);

    logic [11:0] sel_ctl_idx;
    assign sel_ctl_idx = IDX_BASE + 12'({win_sel, 2'b10});

    // R1: first cycle out of reset shows no hit
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !win_hit);

    // R12: a hit is only ever the result of an access one edge earlier
    assert_hit_needs_access_R12: assert property (@(posedge clk) disable iff (rst)
        win_hit |-> $past(io_valid));

    // R12: all result fields are quiet without a hit
    assert_quiet_on_miss_R12: assert property (@(posedge clk) disable iff (rst)
        !win_hit |-> (sock_sel == 3'd0 && wait_cnt == 5'd0 && !cyc16
                      && card_addr == 16'd0 && win_sel == '0));

    // R13: the winning window reads back with its accessed bit set
    assert_acc_marks_R13: assert property (@(posedge clk) disable iff (rst)
        (win_hit && cfg_addr == sel_ctl_idx) |-> cfg_rdata[8]);

    for (genvar w = 0; w < NWIN; w++) begin : g_r3
        localparam logic [11:0] B_IDX = IDX_BASE + 12'(4 * w);
        localparam logic [11:0] C_IDX = B_IDX + 12'd2;
        // R3: writing a base word leaves that window disabled
        assert_base_write_disables_R3: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && cfg_addr == B_IDX) |=> (cfg_addr != C_IDX || !cfg_rdata[15]));
    end

endmodule

bind iowin_decoder iowin_decoder_chk #(.NWIN(NWIN), .IDX_BASE(IDX_BASE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .io_valid  (io_valid),
    .win_hit   (win_hit),
    .win_sel   (win_sel),
    .sock_sel  (sock_sel),
    .wait_cnt  (wait_cnt),
    .cyc16     (cyc16),
    .card_addr (card_addr)
);

// File: tb/iowin_decoder_tb.sv
module iowin_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        io_valid = 1'b0;
    logic [15:0] io_addr = '0;
    logic        card_iois16 = 1'b0;
    logic        win_hit;
    logic [1:0]  win_sel;
    logic [2:0]  sock_sel;
    logic [4:0]  wait_cnt;
    logic        cyc16;
    logic [15:0] card_addr;

    int unsigned mb [NW];
    int unsigned mc [NW];
    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iowin_decoder u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_valid(io_valid),
        .io_addr(io_addr), .card_iois16(card_iois16), .win_hit(win_hit),
        .win_sel(win_sel), .sock_sel(sock_sel), .wait_cnt(wait_cnt),
        .cyc16(cyc16), .card_addr(card_addr)
    );

    task automatic chk(string tag, string what, int unsigned act, int unsigned exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int unsigned model_rd(int unsigned a);
        if (a >= 'h200 && a < 'h200 + 4*NW)
            return (a & 2) ? mc[(a - 'h200) / 4] : mb[(a - 'h200) / 4];
        return 0;
    endfunction

    // Behavioural lookup: first enabled window that contains the address
    task automatic lookup(input int unsigned a, input bit iois,
                          output bit h, output int unsigned wn, output int unsigned s,
                          output int unsigned wt, output bit c16, output int unsigned ca);
        h = 0; wn = 0; s = 0; wt = 0; c16 = 0; ca = 0;
        for (int w = NW - 1; w >= 0; w--) begin
            int unsigned size, lowb, keep, mode;
            bit found;
            if (((mc[w] >> 15) & 1) == 0) continue;
            size = 65536; found = 0;
            if ((mc[w] >> 9) & 1) size = 1;
            else for (int k = 0; k < 16; k++)
                if (!found && ((mb[w] >> k) & 1)) begin size = 2 << k; found = 1; end
            lowb = size - 1;
            keep = ((mc[w] >> 7) & 1) ? 'h3FF : 'hFFFF;
            if ((a & ~lowb & keep) != (mb[w] & ~lowb & keep)) continue;
            h = 1; wn = w;
            s = (mc[w] >> 12) & 7;
            wt = mc[w] & 'h1F;
            ca = (((mc[w] >> 7) & 1) && !((mc[w] >> 5) & 1)) ? (a & 'h3FF) : a;
            mode = (mc[w] >> 10) & 3;
            case (mode)
                0: c16 = iois;
                1: c16 = 1;
                2: c16 = 0;
                default: c16 = (((a & lowb) % 8) == 0);
            endcase
        end
    endtask

    task automatic cycle(string tag);
        bit h, c16;
        int unsigned wn, s, wt, ca;
        lookup(io_addr, card_iois16, h, wn, s, wt, c16, ca);
        if (!io_valid) begin h = 0; wn = 0; s = 0; wt = 0; c16 = 0; ca = 0; end
        @(posedge clk);
        if (cfg_we && cfg_addr >= 'h200 && cfg_addr < 'h200 + 4*NW) begin
            if (cfg_addr[1]) mc[(cfg_addr - 'h200) / 4] = cfg_wdata;
            else begin
                mb[(cfg_addr - 'h200) / 4] = cfg_wdata;
                mc[(cfg_addr - 'h200) / 4] &= ~32'h8000;
            end
        end
        if (h) mc[wn] |= 'h100;
        #1;
        chk(tag, "win_hit", win_hit, h);
        chk(tag, "win_sel", win_sel, wn);
        chk(tag, "sock_sel", sock_sel, s);
        chk(tag, "wait_cnt", wait_cnt, wt);
        chk(tag, "cyc16", cyc16, c16);
        chk(tag, "card_addr", card_addr, ca);
    endtask

    task automatic wr(int unsigned a, int unsigned d, string tag);
        cfg_we = 1; cfg_addr = 12'(a); cfg_wdata = 16'(d); io_valid = 0;
        cycle(tag);
        cfg_we = 0;
    endtask

    task automatic io(int unsigned a, bit iois, string tag);
        io_valid = 1; io_addr = 16'(a); card_iois16 = iois;
        cycle(tag);
        io_valid = 0;
    endtask

    task automatic rd(int unsigned a, string tag);
        @(negedge clk);
        cfg_addr = 12'(a);
        #1;
        chk(tag, "cfg_rdata", cfg_rdata, model_rd(a));
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < NW; w++) begin mb[w] = 0; mc[w] = 0; end
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1: reset state
        cycle("R1");
        for (int i = 0; i < 2*NW; i++) rd('h200 + 2*i, "R1");

        // R2: map and out-of-range writes
        wr('h200, 'h0300, "R2");
        wr('h202, 'h9003, "R2");
        rd('h202, "R2");
        rd('h200, "R2");
        wr('h210, 'hFFFF, "R2");
        wr('h1FE, 'hFFFF, "R2");
        rd('h210, "R2");
        rd('h1FE, "R2");

        // R4, R8, R13: window 0 spans 0x200-0x3FF, dynamic width
        io('h0200, 1, "R8");
        io('h03FF, 0, "R8");
        io('h0400, 1, "R4");
        io('h01FF, 1, "R4");
        rd('h202, "R13");

        // R3: base write disables
        wr('h206, 'h8000, "R3");
        wr('h204, 'h0108, "R3");
        rd('h206, "R3");
        io('h0100, 0, "R3");

        // R10: ATA mode on 0x100-0x10F
        wr('h206, 'hAC05, "R10");
        io('h0100, 0, "R10");
        io('h0104, 1, "R10");
        io('h0108, 0, "R10");
        io('h010F, 1, "R10");

        // R5, R9: single-byte, forced 16
        wr('h208, 'h0061, "R5");
        wr('h20A, 'hB600, "R5");
        io('h0061, 0, "R5");
        io('h0060, 0, "R5");
        io('h0062, 0, "R5");

        // R6, R7, R9: 1 KB alias, forced 8
        wr('h20C, 'h0044, "R6");
        wr('h20E, 'hC880, "R6");
        io('hFC42, 1, "R6");
        io('h0047, 1, "R9");
        // R13: write and hit on the same window in one cycle
        cfg_we = 1; cfg_addr = 12'h20E; cfg_wdata = 16'hC8A0;
        io_valid = 1; io_addr = 16'hFC43; card_iois16 = 1;
        cycle("R13");
        cfg_we = 0; io_valid = 0;
        rd('h20E, "R13");
        io('hFC42, 0, "R7");

        // R12: no access, no hit
        io_addr = 16'h0200; io_valid = 0;
        cycle("R12");

        // R11: overlap of windows 0 and 1
        wr('h204, 'h0380, "R11");
        wr('h206, 'hAC05, "R11");
        io('h0310, 1, "R11");
        wr('h202, 'h0000, "R11");
        io('h0310, 0, "R11");
        io('h0311, 1, "R11");

        // R4: zero base covers everything
        wr('h208, 'h0000, "R4");
        wr('h20A, 'h8007, "R4");
        io('h1234, 0, "R4");
        io('h0320, 0, "R4");
        rd('h20A, "R13");

        done = 1;
        summary();
        $finish;
    end

endmodule